// File: doc/BRIEF.md
# Lane Alignment Monitor with Frame Concealment

This block sits on the receive side of one lane of a multi-gigabit converter link, directly after the 8b/10b decoder. On each clock it takes one decoded octet, together with a flag marking it as a control character and the decoder's disparity and not-in-table error flags. A local frame counter outside the block supplies two boundary strobes. One marks the final octet of a frame. The other marks the final octet of a multi-frame, and it is only ever high together with the frame strobe. The block rebuilds whole frames from these inputs. When a frame holds any decode error, the block delivers the previous good frame again instead, and it raises an error flag alongside it.

The transmitter may replace the last octet of a frame with an end-of-frame alignment character, K28.7 (control octet `8'hFC`). It may replace the last octet of a multi-frame with an end-of-multi-frame alignment character, K28.3 (control octet `8'h7C`). The monitor turns every such character back into data: it substitutes the last octet of the frame it delivered most recently. It also checks where these characters sit. One that arrives off its boundary counts as misplaced. When two alignment characters in a row are both misplaced, a sticky misalignment flag rises.

There are two state machines. The alignment tracker has three states: `ALN_OK`, `ALN_SUSPECT` and `ALN_LOST`. A misplaced character moves it from `ALN_OK` to `ALN_SUSPECT`. A correctly placed character returns it from `ALN_SUSPECT` to `ALN_OK`. A second misplaced character moves it from `ALN_SUSPECT` to `ALN_LOST`. `ALN_LOST` is left only through reset. The frame tracker has two states. `FR_HUNT` moves to `FR_LOCKED` on the first error-free frame end. `FR_LOCKED` is left only through reset.

Top module: `lane_align_monitor`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs become zero after that edge: `frm_data`, `frm_stb`, `frm_err`, `frm_valid` and `misalign`.
- R2: An octet is one of the frame's octets if it arrives in the cycle that `frame_end` is high, or in one of the OCT_PER_FRM-1 cycles just before that. In the cycle after `frame_end`, a clean frame appears on `frm_data` with the earliest octet in bits [7:0] and the latest in the top byte.
- R3: `frm_err` is updated in the cycle after each `frame_end`. It is 1 when any octet of that frame had `rx_disp_err` or `rx_nit_err` set, and 0 otherwise. It holds its value between frames.
- R4: For a frame with an error, `frm_data` keeps the previously delivered frame. Before any clean frame has been delivered, that value is all zeros.
- R5: `frm_valid` stays 0 until the strobe of the first clean frame. It rises with that strobe and then stays 1 until reset.
- R6: An octet with `rx_is_ctrl` set and value `8'hFC` or `8'h7C` is taken as data equal to bits [8*OCT_PER_FRM-1 -: 8] of `frm_data` in that same cycle. This holds wherever the octet is placed.
- R7: A control `8'hFC` is misplaced when `frame_end` is low. A control `8'h7C` is misplaced when `mframe_end` is low. `misalign` rises in the cycle after the second of two consecutive misplaced alignment characters. A correctly placed alignment character between two misplaced ones prevents the rise.
- R8: Once set, `misalign` stays high until `rst` clears it.
- R9: Every other octet is passed into the frame unchanged, including control characters with other values.
- R10: `frm_stb` is high for exactly the cycles that follow a cycle with `frame_end` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_octet | input | 8 | Decoded octet |
| rx_is_ctrl | input | 1 | Octet is a control character |
| rx_disp_err | input | 1 | Running disparity error on this octet |
| rx_nit_err | input | 1 | Not-in-table error on this octet |
| frame_end | input | 1 | This octet is the last of its frame |
| mframe_end | input | 1 | This octet is the last of its multi-frame |
| frm_data | output | 8*OCT_PER_FRM | Delivered frame, earliest octet lowest |
| frm_stb | output | 1 | One-cycle pulse per delivered frame |
| frm_err | output | 1 | Last frame held a decode error and was concealed |
| frm_valid | output | 1 | A clean frame has been delivered since reset |
| misalign | output | 1 | Sticky alignment-loss flag |

## Verification
The bench builds the block with OCT_PER_FRM = 3 and uses its own frame counter with four frames per multi-frame. With three octets per frame, an error can be placed at the first, middle and last octet, and a misplaced character can land at a frame start or a frame middle. With four frames per multi-frame, every fourth frame end carries the multi-frame strobe. That makes it possible to send a K28.3 at an ordinary frame end, where it is misplaced, and at the real multi-frame end, where it is legal. The run also sends a bad frame and an alignment character before the first clean frame, so concealment and restoration are both checked against the all-zero reset value.

// File: rtl/lam_pkg.sv
package lam_pkg;

    // End-of-frame and end-of-multi-frame alignment control octets
    localparam logic [7:0] ALIGN_EOF  = 8'hFC;
    localparam logic [7:0] ALIGN_EOMF = 8'h7C;

    typedef enum logic [1:0] {
        ALN_OK      = 2'd0,
        ALN_SUSPECT = 2'd1,
        ALN_LOST    = 2'd2
    } aln_state_t;

    typedef enum logic {
        FR_HUNT   = 1'b0,
        FR_LOCKED = 1'b1
    } frm_state_t;

    // One classified lane symbol
    typedef struct packed {
        logic [7:0] octet;    // data after restoration
        logic       bad;      // decoder flagged an error
        logic       is_align; // octet was an alignment character
        logic       placed;   // alignment character sat on its boundary
    } lane_sym_t;

endpackage

// File: rtl/lam_char_restore.sv
module lam_char_restore
    import lam_pkg::*;
(
    input  logic [7:0] octet_i,
    input  logic       ctrl_i,
    input  logic       disp_err_i,
    input  logic       nit_err_i,
    input  logic       frame_end_i,
    input  logic       mframe_end_i,
    input  logic [7:0] fill_i,
    output lane_sym_t  sym_o
);

    logic is_eof_char;
    logic is_eomf_char;

    always_comb begin
        is_eof_char    = ctrl_i && (octet_i == ALIGN_EOF);
        is_eomf_char   = ctrl_i && (octet_i == ALIGN_EOMF);
        sym_o.is_align = is_eof_char || is_eomf_char;
        sym_o.placed   = (is_eof_char && frame_end_i) ||
                         (is_eomf_char && mframe_end_i);
        sym_o.octet    = sym_o.is_align ? fill_i : octet_i;
        sym_o.bad      = disp_err_i || nit_err_i;
    end

endmodule

// File: rtl/lam_align_fsm.sv
module lam_align_fsm
    import lam_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic is_align_i,
    input  logic placed_i,
    output logic misalign_o
);

    aln_state_t state_q;
    aln_state_t state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ALN_OK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALN_OK: begin
                if (is_align_i && !placed_i) begin
                    state_d = ALN_SUSPECT;
                end
            end
            ALN_SUSPECT: begin
                if (is_align_i) begin
                    state_d = placed_i ? ALN_OK : ALN_LOST;
                end
            end
            ALN_LOST: begin
                state_d = ALN_LOST;
            end
            default: begin
                state_d = ALN_LOST;
            end
        endcase
    end

    always_comb begin
        misalign_o = (state_q == ALN_LOST);
    end

endmodule

// File: rtl/lam_frame_conceal.sv
module lam_frame_conceal
    import lam_pkg::*;
#(
    parameter int OCT_PER_FRM = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  lane_sym_t                sym_i,
    input  logic                     frame_end_i,
    output logic [8*OCT_PER_FRM-1:0] frm_data_o,
    output logic                     frm_stb_o,
    output logic                     frm_err_o,
    output logic                     frm_valid_o,
    output logic [7:0]               fill_o
);

    localparam int FRM_W = 8 * OCT_PER_FRM;

    logic [FRM_W-1:0] assembled;
    logic [FRM_W-1:0] data_q;
    logic             stb_q;
    logic             err_q;
    logic             err_acc_q;
    logic             frame_bad;
    frm_state_t       state_q;
    frm_state_t       state_d;

    // Frame assembly: newest octet on top, oldest at the bottom
    generate
        if (OCT_PER_FRM == 1) begin : g_single
            always_comb begin
                assembled = sym_i.octet;
            end
        end else begin : g_shift
            logic [FRM_W-9:0] hist_q;
            always_comb begin
                assembled = {sym_i.octet, hist_q};
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    hist_q <= '0;
                end else begin
                    hist_q <= assembled[FRM_W-1:8];
                end
            end
        end
    endgenerate

    always_comb begin
        frame_bad = err_acc_q || sym_i.bad;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q    <= '0;
            stb_q     <= 1'b0;
            err_q     <= 1'b0;
            err_acc_q <= 1'b0;
        end else begin
            stb_q <= frame_end_i;
            if (frame_end_i) begin
                err_q     <= frame_bad;
                err_acc_q <= 1'b0;
                if (!frame_bad) begin
                    data_q <= assembled;
                end
            end else begin
                err_acc_q <= frame_bad;
            end
        end
    end

    // Frame-lock state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FR_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FR_HUNT: begin
                if (frame_end_i && !frame_bad) begin
                    state_d = FR_LOCKED;
                end
            end
            FR_LOCKED: begin
                state_d = FR_LOCKED;
            end
            default: begin
                state_d = FR_HUNT;
            end
        endcase
    end

    always_comb begin
        frm_data_o  = data_q;
        frm_stb_o   = stb_q;
        frm_err_o   = err_q;
        frm_valid_o = (state_q == FR_LOCKED);
        fill_o      = data_q[FRM_W-1 -: 8];
    end

endmodule

// File: rtl/lane_align_monitor.sv
module lane_align_monitor
    import lam_pkg::*;
#(
    parameter int OCT_PER_FRM = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [7:0]               rx_octet,
    input  logic                     rx_is_ctrl,
    input  logic                     rx_disp_err,
    input  logic                     rx_nit_err,
    input  logic                     frame_end,
    input  logic                     mframe_end,
    output logic [8*OCT_PER_FRM-1:0] frm_data,
    output logic                     frm_stb,
    output logic                     frm_err,
    output logic                     frm_valid,
    output logic                     misalign
);

    lane_sym_t  sym;
    logic [7:0] fill;

    lam_char_restore u_restore (
        .octet_i      (rx_octet),
        .ctrl_i       (rx_is_ctrl),
        .disp_err_i   (rx_disp_err),
        .nit_err_i    (rx_nit_err),
        .frame_end_i  (frame_end),
        .mframe_end_i (mframe_end),
        .fill_i       (fill),
        .sym_o        (sym)
    );

    lam_align_fsm u_align (
        .clk        (clk),
        .rst        (rst),
        .is_align_i (sym.is_align),
        .placed_i   (sym.placed),
        .misalign_o (misalign)
    );

    lam_frame_conceal #(
        .OCT_PER_FRM (OCT_PER_FRM)
    ) u_conceal (
        .clk         (clk),
        .rst         (rst),
        .sym_i       (sym),
        .frame_end_i (frame_end),
        .frm_data_o  (frm_data),
        .frm_stb_o   (frm_stb),
        .frm_err_o   (frm_err),
        .frm_valid_o (frm_valid),
        .fill_o      (fill)
    );

endmodule

// File: rtl/lane_align_monitor_chk.sv
module lane_align_monitor_chk
    import lam_pkg::*;
#(
    parameter int OCT_PER_FRM = 4
) (
    input logic                     clk,
    input logic                     rst,
    input logic [7:0]               rx_octet,
    input logic                     rx_is_ctrl,
    input logic                     rx_disp_err,
    input logic                     rx_nit_err,
    input logic                     frame_end,
    input logic                     mframe_end,
    input logic [8*OCT_PER_FRM-1:0] frm_data,
    input logic                     frm_stb,
    input logic                     frm_err,
    input logic                     frm_valid,
    input logic                     misalign
);

    p_stb_follows_end_r10: assert property (@(posedge clk) disable iff (rst)
        frame_end |=> frm_stb);

    p_no_stray_stb_r10: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> !frm_stb);

    p_err_flagged_r3: assert property (@(posedge clk) disable iff (rst)
        frame_end && (rx_disp_err || rx_nit_err) |=> frm_err);

    p_conceal_hold_r4: assert property (@(posedge clk) disable iff (rst)
        frm_stb && frm_err |-> frm_data == $past(frm_data));

    p_clean_sets_valid_r5: assert property (@(posedge clk) disable iff (rst)
        frm_stb && !frm_err |-> frm_valid);

    p_valid_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        frm_valid |=> frm_valid);

    p_misalign_cause_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(misalign) |-> $past(rx_is_ctrl &&
            ((rx_octet == ALIGN_EOF && !frame_end) ||
             (rx_octet == ALIGN_EOMF && !mframe_end))));

    p_misalign_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        misalign |=> misalign);

endmodule

bind lane_align_monitor lane_align_monitor_chk #(
    .OCT_PER_FRM (OCT_PER_FRM)
) chk_i (.*);

// File: tb/lane_align_monitor_tb_top.sv
`timescale 1ns/1ps
module lane_align_monitor_tb_top;

    localparam int F = 3;
    localparam int K = 4;
    localparam int W = 8 * F;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [7:0]   rx_octet    = '0;
    logic         rx_is_ctrl  = 1'b0;
    logic         rx_disp_err = 1'b0;
    logic         rx_nit_err  = 1'b0;
    logic         frame_end   = 1'b0;
    logic         mframe_end  = 1'b0;
    logic [W-1:0] frm_data;
    logic         frm_stb;
    logic         frm_err;
    logic         frm_valid;
    logic         misalign;

    lane_align_monitor #(.OCT_PER_FRM(F)) dut_i (
        .clk, .rst, .rx_octet, .rx_is_ctrl, .rx_disp_err, .rx_nit_err,
        .frame_end, .mframe_end, .frm_data, .frm_stb, .frm_err,
        .frm_valid, .misalign
    );

    int n_cmp  = 0;
    int n_bad  = 0;
    int pos    = 0;
    int fidx   = 0;
    bit cmp_en = 0;
    bit done   = 0;

    // Behavioural reference state
    logic [7:0]   m_hist[$];
    logic [W-1:0] m_data;
    logic [W-1:0] m_frame;
    logic         m_stb, m_err, m_valid, m_mis, m_acc;
    int           m_cnt;

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        logic [7:0] o;
        logic       placed;
        logic       bad;
        if (rst) begin
            m_hist.delete();
            for (int i = 0; i < F; i++) m_hist.push_back(8'h00);
            m_data = '0; m_stb = 0; m_err = 0; m_valid = 0; m_mis = 0;
            m_acc = 0; m_cnt = 0;
        end else begin
            o = rx_octet;
            if (rx_is_ctrl && (rx_octet == 8'hFC || rx_octet == 8'h7C)) begin
                placed = (rx_octet == 8'hFC) ? frame_end : mframe_end;
                o = m_data[W-1 -: 8];
                if (placed) m_cnt = 0;
                else m_cnt++;
                if (m_cnt >= 2) m_mis = 1;
            end
            m_hist.push_back(o);
            void'(m_hist.pop_front());
            bad = rx_disp_err | rx_nit_err;
            m_stb = frame_end;
            if (frame_end) begin
                for (int i = 0; i < F; i++) m_frame[8*i +: 8] = m_hist[i];
                m_err = m_acc | bad;
                if (!m_err) begin
                    m_data  = m_frame;
                    m_valid = 1;
                end
                m_acc = 0;
            end else begin
                m_acc = m_acc | bad;
            end
        end
        cmp_en = 1;
    end

    always @(negedge clk) begin
        if (cmp_en && !done) begin
            check("R2 R4 R6 R9 frm_data", frm_data, m_data);
            check("R10 frm_stb", W'(frm_stb), W'(m_stb));
            check("R3 frm_err", W'(frm_err), W'(m_err));
            check("R5 frm_valid", W'(frm_valid), W'(m_valid));
            check("R7 R8 misalign", W'(misalign), W'(m_mis));
        end
    end

    task automatic put(input logic [7:0] oct, input logic ctl, input logic d, input logic n);
        @(negedge clk);
        rx_octet    = oct;
        rx_is_ctrl  = ctl;
        rx_disp_err = d;
        rx_nit_err  = n;
        frame_end   = (pos == F-1);
        mframe_end  = (pos == F-1) && (fidx == K-1);
        if (pos == F-1) begin
            pos  = 0;
            fidx = (fidx + 1) % K;
        end else begin
            pos++;
        end
    endtask

    // aln: 0 none, 1 legal char at frame end, 2 FC at octet 0,
    //      3 7C at frame end (misplaced unless multi-frame end), 4 K28.5 at octet 1
    task automatic frame(input int seed, input int errpos, input int errkind, input int aln);
        for (int i = 0; i < F; i++) begin
            logic [7:0] v;
            logic       c;
            v = 8'(seed * 29 + i * 53 + 7);
            c = 1'b0;
            if (aln == 1 && i == F-1) begin
                v = (fidx == K-1) ? 8'h7C : 8'hFC;
                c = 1'b1;
            end
            if (aln == 2 && i == 0) begin v = 8'hFC; c = 1'b1; end
            if (aln == 3 && i == F-1) begin v = 8'h7C; c = 1'b1; end
            if (aln == 4 && i == 1) begin v = 8'hBC; c = 1'b1; end
            put(v, c, (i == errpos) && (errkind == 1), (i == errpos) && (errkind == 2));
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        rx_octet = '0; rx_is_ctrl = 0; rx_disp_err = 0; rx_nit_err = 0;
        frame_end = 0; mframe_end = 0;
        pos = 0; fidx = 0;
        @(negedge clk);
        @(negedge clk);
        check("R1 frm_data", frm_data, '0);
        check("R1 frm_stb", W'(frm_stb), '0);
        check("R1 frm_err", W'(frm_err), '0);
        check("R1 frm_valid", W'(frm_valid), '0);
        check("R1 misalign", W'(misalign), '0);
        rst = 1'b0;
    endtask

    task automatic check_mis(input string tag, input logic exp);
        @(posedge clk);
        #1;
        check(tag, W'(misalign), W'(exp));
    endtask

    initial begin
        do_reset();
        frame(1, 1, 2, 0);            // bad frame before any clean one (R4 R5)
        frame(2, -1, 0, 1);           // alignment char restored from zeros (R6)
        for (int s = 3; s < 9; s++) frame(s, -1, 0, 0);
        frame(10, 0, 1, 0);           // disparity error, first octet (R3 R4)
        frame(11, -1, 0, 0);
        frame(12, 2, 2, 0);           // not-in-table error, last octet
        frame(13, 1, 1, 0);
        frame(14, -1, 0, 4);          // other control character passes (R9)
        for (int s = 15; s < 23; s++) frame(s, -1, 0, 1);
        frame(23, -1, 0, 2);          // one misplaced
        frame(24, -1, 0, 1);          // correctly placed in between
        check_mis("R7 no rise after single misplaced", 1'b0);
        frame(25, -1, 0, 2);
        frame(26, -1, 0, 0);
        while (fidx == K-1) frame(27, -1, 0, 0);
        frame(28, -1, 0, 3);          // 7C away from multi-frame end
        check_mis("R7 rise after two misplaced", 1'b1);
        for (int s = 29; s < 33; s++) frame(s, -1, 0, 1);
        frame(33, 0, 2, 0);
        check_mis("R8 still set", 1'b1);
        do_reset();
        check_mis("R8 cleared by reset", 1'b0);
        for (int s = 40; s < 44; s++) frame(s, -1, 0, 0);
        frame(44, 2, 1, 1);
        frame(45, -1, 0, 0);
        @(negedge clk);
        frame_end = 0; mframe_end = 0; rx_is_ctrl = 0;
        rx_disp_err = 0; rx_nit_err = 0;
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule